// File: doc/BRIEF.md
# Cell-Pointer Transmit Buffer Writer

This block takes the payload of one transmit packet at a time from a host-side FIFO and stores it in an external buffer memory. That memory is organised as fixed-size cells. Each cell is named by a pointer taken from a free-pool allocator. Cells need not be contiguous. The block asks for a new pointer only when the FIFO already holds enough words to fill the next cell, or to finish the packet if fewer words remain.

Each packet opens with a start strobe that carries its length in bytes. When the last word has been stored, the block offers a control-list entry to a queue. The entry holds the stored length, the number of cells and every pointer used, in the order they were filled. It also raises a one-cycle interrupt once the queue accepts the entry.

A packet too long for the pointer slots of one entry is cut short. Its excess words are drained from the FIFO and discarded, and the entry is marked with an error flag. Whenever the pool or the queue is not ready, the block stalls without losing data.

Top module: `txcell_writer`

## Requirements
- R1: After reset, ptr_req_o, fifo_rd_o, mem_we_o, q_push_o and irq_o are all low.
- R2: A packet of len bytes carries ceil(len/4) words. A pointer is requested only while fifo_count_i is at least min(64, words still to store). The request is held until granted.
- R3: Word k of a packet (k counted from 0) is written unchanged to address ptr*64 + (k mod 64). Here ptr is the pointer granted for cell k/64, and the address is the pointer concatenated with a 6-bit offset.
- R4: After the last word, the entry carries the length in bytes in q_len_o and the cell count ceil(words/64) in q_cnt_o. The granted pointers sit in q_ptrs_o, with slot i at bits [12*i+11:12*i]. Unused slots read zero.
- R5: irq_o is high for exactly one cycle, in the cycle after the entry is accepted (q_push_o high and q_full_i low). There is one such pulse per packet.
- R6: Any byte length is accepted, and the last cell may be partly filled. A zero-length packet gives an entry with count 0 and length 0, and requests no pointer.
- R7: A packet needing more than 8 cells stores only its first 512 words. Its remaining words are read from the FIFO and not written to memory. Its entry shows count 8, length 2048 and q_trunc_o = 1.
- R8: While a pointer request is pending, no FIFO word is read and no memory write occurs. The FIFO is never read when empty.
- R9: While q_full_i is high, q_push_o stays high with an unchanged entry and irq_o stays low.
- R10: A start strobe is ignored unless the block is idle, including in the cycle in which a pending entry is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Packet start strobe |
| len_i | input | 16 | Packet length in bytes, valid with start_i |
| fifo_count_i | input | 8 | Words held by the transmit FIFO |
| fifo_data_i | input | 32 | Head word of the FIFO (show-ahead) |
| fifo_rd_o | output | 1 | Pop the FIFO head |
| ptr_req_o | output | 1 | Cell pointer request |
| ptr_gnt_i | input | 1 | Pointer grant |
| ptr_i | input | 12 | Granted cell pointer |
| mem_we_o | output | 1 | Buffer memory write enable |
| mem_addr_o | output | 18 | Buffer memory word address |
| mem_data_o | output | 32 | Buffer memory write data |
| q_push_o | output | 1 | Control-list entry valid |
| q_full_i | input | 1 | Control-list queue full |
| q_len_o | output | 16 | Entry: stored length in bytes |
| q_cnt_o | output | 4 | Entry: number of cells |
| q_ptrs_o | output | 96 | Entry: cell pointers, slot 0 in the low bits |
| q_trunc_o | output | 1 | Entry: truncation error flag |
| irq_o | output | 1 | Entry pushed interrupt pulse |

## Verification
The finishing step of one packet and the opening of the next can meet in a single cycle. A start strobe may arrive in the very cycle the queue releases its full signal and accepts a pending entry. The bench provokes this by holding the queue full, then dropping q_full_i and pulsing start_i at the same edge. It judges that the earlier entry is delivered intact with one interrupt, and that the colliding strobe is dropped, so no pointer is requested and no second entry appears. A following packet is then stored normally.

// File: rtl/txcell_writer.sv
module txcell_writer #(
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 8,
  parameter int PTR_W      = 12,
  parameter int CELL_WORDS = 64,
  parameter int MAX_CELLS  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [LEN_W-1:0]           len_i,
  input  logic [CNT_W-1:0]           fifo_count_i,
  input  logic [DATA_W-1:0]          fifo_data_i,
  output logic                       fifo_rd_o,
  output logic                       ptr_req_o,
  input  logic                       ptr_gnt_i,
  input  logic [PTR_W-1:0]           ptr_i,
  output logic                       mem_we_o,
  output logic [PTR_W+$clog2(CELL_WORDS)-1:0] mem_addr_o,
  output logic [DATA_W-1:0]          mem_data_o,
  output logic                       q_push_o,
  input  logic                       q_full_i,
  output logic [LEN_W-1:0]           q_len_o,
  output logic [$clog2(MAX_CELLS+1)-1:0] q_cnt_o,
  output logic [MAX_CELLS*PTR_W-1:0] q_ptrs_o,
  output logic                       q_trunc_o,
  output logic                       irq_o
);
  localparam int BPW       = DATA_W / 8;
  localparam int OFS_W     = $clog2(CELL_WORDS);
  localparam int SLOT_W    = $clog2(MAX_CELLS + 1);
  localparam int WRD_W     = LEN_W + 1;
  localparam int MAX_WORDS = MAX_CELLS * CELL_WORDS;
  localparam int MAX_BYTES = MAX_WORDS * BPW;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_REQ, S_WRITE, S_DRAIN, S_PUSH} st_t;

  st_t              st;
  logic [WRD_W-1:0] rem;
  logic [OFS_W-1:0] ofs;
  logic [SLOT_W-1:0] ncell;
  logic [PTR_W-1:0] cur;
  logic [PTR_W-1:0] slot [MAX_CELLS];
  logic [LEN_W-1:0] len_q;
  logic             trunc_q;
  logic             irq_q;

  logic [WRD_W-1:0] start_words, need, have;
  logic             avail, last_in_cell;

  assign start_words  = (WRD_W'(len_i) + WRD_W'(BPW - 1)) / WRD_W'(BPW);
  assign need         = (rem < WRD_W'(CELL_WORDS)) ? rem : WRD_W'(CELL_WORDS);
  assign have         = WRD_W'(fifo_count_i);
  assign avail        = fifo_count_i != '0;
  assign last_in_cell = (ofs == OFS_W'(CELL_WORDS - 1)) || (rem == WRD_W'(1));

  assign fifo_rd_o  = (st == S_WRITE || st == S_DRAIN) && avail;
  assign mem_we_o   = (st == S_WRITE) && avail;
  assign mem_addr_o = {cur, ofs};
  assign mem_data_o = fifo_data_i;
  assign ptr_req_o  = st == S_REQ;
  assign q_push_o   = st == S_PUSH;
  assign q_len_o    = len_q;
  assign q_cnt_o    = ncell;
  assign q_trunc_o  = trunc_q;
  assign irq_o      = irq_q;

  for (genvar g = 0; g < MAX_CELLS; g++) begin : g_slots
    assign q_ptrs_o[g*PTR_W +: PTR_W] = slot[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      rem     <= '0;
      ofs     <= '0;
      ncell   <= '0;
      cur     <= '0;
      len_q   <= '0;
      trunc_q <= 1'b0;
      irq_q   <= 1'b0;
      for (int i = 0; i < MAX_CELLS; i++) slot[i] <= '0;
    end else begin
      irq_q <= (st == S_PUSH) && !q_full_i;
      unique case (st)
        S_IDLE: if (start_i) begin
          rem     <= start_words;
          ofs     <= '0;
          ncell   <= '0;
          trunc_q <= start_words > WRD_W'(MAX_WORDS);
          len_q   <= (start_words > WRD_W'(MAX_WORDS)) ? LEN_W'(MAX_BYTES) : len_i;
          for (int i = 0; i < MAX_CELLS; i++) slot[i] <= '0;
          st      <= (start_words == '0) ? S_PUSH : S_WAIT;
        end
        S_WAIT: if (have >= need) st <= S_REQ;
        S_REQ: if (ptr_gnt_i) begin
          cur <= ptr_i;
          for (int i = 0; i < MAX_CELLS; i++)
            if (ncell == SLOT_W'(i)) slot[i] <= ptr_i;
          ncell <= ncell + 1'b1;
          st    <= S_WRITE;
        end
        S_WRITE: if (avail) begin
          rem <= rem - 1'b1;
          ofs <= ofs + 1'b1;
          if (last_in_cell) begin
            ofs <= '0;
            if (rem == WRD_W'(1))                 st <= S_PUSH;
            else if (ncell == SLOT_W'(MAX_CELLS)) st <= S_DRAIN;
            else                                  st <= S_WAIT;
          end
        end
        S_DRAIN: if (avail) begin
          rem <= rem - 1'b1;
          if (rem == WRD_W'(1)) st <= S_PUSH;
        end
        S_PUSH: if (!q_full_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_threshold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req_o |-> have >= need);
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req_o && !ptr_gnt_i |=> ptr_req_o);
  assert_no_read_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req_o |-> !fifo_rd_o && !mem_we_o);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_o |-> fifo_count_i != '0);
  assert_write_has_cell_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ncell != '0 && ncell <= SLOT_W'(MAX_CELLS));
  assert_push_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_push_o && q_full_i |=> q_push_o && $stable(q_len_o) && $stable(q_ptrs_o) && !irq_o);
  assert_irq_after_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(q_push_o && !q_full_i));
  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
endmodule

// File: tb/txcell_writer_bench.sv
`timescale 1ns/100ps
module txcell_writer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] len_i = '0;
  logic [7:0]  fifo_count_i = '0;
  logic [31:0] fifo_data_i = '0;
  logic        fifo_rd_o, ptr_req_o, ptr_gnt_i, mem_we_o, q_push_o, q_trunc_o, irq_o;
  logic [11:0] ptr_i;
  logic [17:0] mem_addr_o;
  logic [31:0] mem_data_o;
  logic        q_full_i = 1'b0;
  logic [15:0] q_len_o;
  logic [3:0]  q_cnt_o;
  logic [95:0] q_ptrs_o;

  txcell_writer u_txcell_writer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .fifo_count_i(fifo_count_i), .fifo_data_i(fifo_data_i), .fifo_rd_o(fifo_rd_o),
    .ptr_req_o(ptr_req_o), .ptr_gnt_i(ptr_gnt_i), .ptr_i(ptr_i),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .q_push_o(q_push_o), .q_full_i(q_full_i), .q_len_o(q_len_o), .q_cnt_o(q_cnt_o),
    .q_ptrs_o(q_ptrs_o), .q_trunc_o(q_trunc_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0, writes = 0, irq_cnt = 0;
  logic [31:0] fq[$];
  logic [31:0] mem[int];
  logic [11:0] gp[$];
  logic [11:0] next_ptr = 12'd5;
  logic        gnt_en = 1'b1;
  logic        e_valid = 1'b0;
  logic [15:0] e_len;
  logic [3:0]  e_cnt;
  logic        e_trunc;
  logic [95:0] e_ptrs;

  assign ptr_gnt_i = gnt_en & ptr_req_o;
  assign ptr_i     = next_ptr;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (fifo_rd_o && fq.size() > 0) void'(fq.pop_front());
    fifo_count_i <= (fq.size() > 255) ? 8'd255 : 8'(fq.size());
    fifo_data_i  <= (fq.size() > 0) ? fq[0] : 32'h0;
    if (mem_we_o) begin
      mem[int'(mem_addr_o)] = mem_data_o;
      writes <= writes + 1;
    end
    if (ptr_req_o && ptr_gnt_i) begin
      gp.push_back(next_ptr);
      next_ptr <= next_ptr + 12'd3;
    end
    if (q_push_o && !q_full_i) begin
      e_valid <= 1'b1;
      e_len <= q_len_o; e_cnt <= q_cnt_o; e_trunc <= q_trunc_o; e_ptrs <= q_ptrs_o;
    end
    if (irq_o) irq_cnt <= irq_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_pkt();
    @(negedge clk);
    e_valid = 1'b0; irq_cnt = 0; writes = 0; gp.delete(); mem.delete();
  endtask

  task automatic send_start(input int len);
    @(negedge clk);
    start_i = 1'b1; len_i = 16'(len);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic feed(input int id, input int first, input int n);
    for (int k = first; k < first + n; k++) fq.push_back({16'(id), 16'(k)});
  endtask

  task automatic wait_entry(input string tag);
    int t = 0;
    while (!e_valid && t < 5000) begin @(negedge clk); t++; end
    check(e_valid, tag, "entry pushed", e_valid, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input string tag, input int id, input int len, input bit trunc);
    int words  = (len + 3) / 4;
    int stored = (words > 512) ? 512 : words;
    int cells  = (stored + 63) / 64;
    int bad = 0;
    int mism_exp = 0, mism_act = 0;
    check(e_len == 16'(trunc ? 2048 : len), tag, "entry length", e_len, trunc ? 2048 : len);
    check(e_cnt == 4'(cells), tag, "cell count", e_cnt, cells);
    check(e_trunc == trunc, tag, "trunc flag", e_trunc, trunc);
    check(gp.size() == cells, tag, "pointers granted", gp.size(), cells);
    for (int s = 0; s < 8; s++) begin
      logic [11:0] want = (s < gp.size()) ? gp[s] : 12'h0;
      if (e_ptrs[s*12 +: 12] != want) bad++;
    end
    check(bad == 0, tag, "pointer slots mismatching", bad, 0);
    bad = 0;
    for (int k = 0; k < stored && gp.size() == cells; k++) begin
      int a = int'(gp[k/64]) * 64 + (k % 64);
      logic [31:0] exp = {16'(id), 16'(k)};
      if (!mem.exists(a) || mem[a] !== exp) begin
        if (bad == 0) begin mism_exp = int'(exp); mism_act = mem.exists(a) ? int'(mem[a]) : -1; end
        bad++;
      end
    end
    if (bad != 0) check(1'b0, tag, "payload first wrong word", mism_act, mism_exp);
    else check(1'b1, tag, "payload", 0, 0);
    check(writes == stored, tag, "memory writes", writes, stored);
    check(fq.size() == 0, tag, "fifo drained", fq.size(), 0);
    check(irq_cnt == 1, tag, "interrupt pulses", irq_cnt, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!ptr_req_o && !fifo_rd_o && !mem_we_o && !q_push_o && !irq_o, "R1", "idle outputs",
          {ptr_req_o, fifo_rd_o, mem_we_o, q_push_o, irq_o}, 0);
  endtask

  task automatic t_plain(input int id, input int len, input string tag);
    clear_pkt();
    send_start(len);
    feed(id, 0, (len + 3) / 4);
    wait_entry(tag);
    verify(tag, id, len, 1'b0);
  endtask

  task automatic t_threshold_and_pool();
    clear_pkt();
    gnt_en = 1'b0;
    send_start(400);
    feed(20, 0, 63);
    repeat (10) @(negedge clk);
    check(ptr_req_o == 1'b0, "R2", "no request below cell", ptr_req_o, 0);
    feed(20, 63, 1);
    repeat (4) @(negedge clk);
    check(ptr_req_o == 1'b1, "R2", "request at full cell", ptr_req_o, 1);
    repeat (20) @(negedge clk);
    check(writes == 0, "R8", "writes while grant withheld", writes, 0);
    check(fq.size() == 64, "R8", "fifo untouched while pending", fq.size(), 64);
    check(ptr_req_o == 1'b1, "R2", "request held", ptr_req_o, 1);
    gnt_en = 1'b1;
    while (writes < 64) @(negedge clk);
    feed(20, 64, 35);
    repeat (10) @(negedge clk);
    check(gp.size() == 1, "R2", "no request below remainder", gp.size(), 1);
    feed(20, 99, 1);
    wait_entry("R3");
    verify("R3", 20, 400, 1'b0);
  endtask

  task automatic t_trunc();
    clear_pkt();
    send_start(2100);
    feed(30, 0, 525);
    wait_entry("R7");
    verify("R7", 30, 2100, 1'b1);
  endtask

  task automatic t_zero();
    clear_pkt();
    send_start(0);
    wait_entry("R6");
    verify("R6", 0, 0, 1'b0);
  endtask

  task automatic t_busy_start();
    clear_pkt();
    send_start(300);
    feed(40, 0, 10);
    repeat (3) @(negedge clk);
    send_start(8);
    feed(40, 10, 65);
    wait_entry("R10");
    verify("R10", 40, 300, 1'b0);
  endtask

  task automatic t_queue_full_collision();
    int t = 0;
    clear_pkt();
    q_full_i = 1'b1;
    send_start(20);
    feed(50, 0, 5);
    while (!q_push_o && t < 2000) begin @(negedge clk); t++; end
    repeat (10) @(negedge clk);
    check(q_push_o == 1'b1, "R9", "entry held while full", q_push_o, 1);
    check(irq_cnt == 0, "R9", "no interrupt while full", irq_cnt, 0);
    check(q_len_o == 16'd20, "R9", "held length", q_len_o, 20);
    q_full_i = 1'b0; start_i = 1'b1; len_i = 16'd40;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    verify("R9", 50, 20, 1'b0);
    check(ptr_req_o == 1'b0 && !q_push_o, "R10", "colliding start dropped",
          {ptr_req_o, q_push_o}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain(1, 10, "R6");
    t_plain(2, 256, "R4");
    t_plain(3, 257, "R4");
    t_plain(4, 1000, "R3");
    t_threshold_and_pool();
    t_trunc();
    t_zero();
    t_busy_start();
    t_queue_full_collision();
    t_plain(5, 130, "R5");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule